// File: doc/BRIEF.md
# DMA Controller Host Register Front End

This block is the processor-facing register decoder of a four-channel DMA engine. The host drives an 8-bit data bus, a 4-bit register address and separate read and write strobes. Address bit 3 set selects the control page. The low three address bits then pick one of eight locations, and the direction of the access changes the meaning of each location. The block holds the 8-bit command register, four per-channel mode registers and a two-bit readback counter for the mode registers. It also carries out master clear. The status, request, mask and temporary registers belong to neighbouring blocks. This block reads their values in for host reads and sends one-cycle pulses out for their updates.

Several locations are commands that act through the access alone. The set and clear of the byte-order flip-flop, master clear, clear of the readback counter and clear of all masks ignore the data bus. Each strobe assertion is detected on its first cycle. It gives exactly one pulse and one read capture, however long the host holds the strobe.

Top module: `dma_regfront`

## Requirements
- R1: After reset the command register, the mode registers, the readback counter, every pulse output, `p_wdata` and `rdata` are zero.
- R2: A write to address 4'b1000 loads the command register. Its bits are decoded as: bit 0 memory-to-memory enable, bit 1 channel 0 address hold, bit 2 controller disable, bit 3 compressed timing, bit 4 rotating priority, bit 5 extended write, bit 6 request input active low, bit 7 acknowledge active high. Apart from master clear, nothing else changes the command register.
- R3: A write to address 4'b1011 uses data bits 1:0 to pick the channel. For that channel it stores bits 3:2 (transfer type), bit 4 (autoinitialize), bit 5 (address decrement) and bits 7:6 (service mode). The packed outputs put channel n at slice n.
- R4: A read of address 4'b1011 returns the mode bits of the channel the readback counter points to, with bits 1:0 forced to 11. The counter then advances by one, wrapping from 3 to 0.
- R5: A read of address 4'b1110 resets the readback counter to 0. A write of address 4'b1110 pulses `p_clr_mask`. Neither depends on the data bus.
- R6: A read of address 4'b1100 pulses `p_ff_set`. A write of address 4'b1100 pulses `p_ff_clr`. The data bus has no effect.
- R7: A write of address 4'b1101 pulses `p_mclr`, whatever the data. It clears the command register and the readback counter and keeps the mode registers.
- R8: Writes to 4'b1001, 4'b1010 and 4'b1111 pulse `p_req_wr`, `p_mask_one` and `p_mask_all` respectively. On every control-page write, `p_wdata` takes the written byte.
- R9: On a read, `rdata` is loaded as follows. Address 4'b1000 gives `status_in` and pulses `p_status_rd`. Address 4'b1001 gives {4'hF, `req_in`}. Address 4'b1010 gives the command register. Address 4'b1101 gives `temp_in`. Address 4'b1111 gives {4'hF, `mask_in`}. Addresses 4'b1100 and 4'b1110 give 8'h00.
- R10: Pulses and `rdata` update one clock after the first cycle of a strobe assertion. Each pulse lasts one clock. A held strobe never triggers again.
- R11: Accesses with address bit 3 clear produce no pulse and change no register, including `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, active high |
| rd_en | input | 1 | Host read strobe, active high |
| addr | input | 4 | Register address |
| wdata | input | 8 | Host write data |
| status_in | input | 8 | Status byte from the channel logic |
| req_in | input | 4 | Request bits from the channel logic |
| mask_in | input | 4 | Mask bits from the channel logic |
| temp_in | input | 8 | Temporary byte from the transfer logic |
| rdata | output | 8 | Captured read data |
| mem2mem_en | output | 1 | Command bit 0 |
| ch0_hold | output | 1 | Command bit 1 |
| ctrl_off | output | 1 | Command bit 2 |
| timing_short | output | 1 | Command bit 3 |
| prio_rotate | output | 1 | Command bit 4 |
| write_ext | output | 1 | Command bit 5 |
| dreq_inv | output | 1 | Command bit 6 |
| dack_hi | output | 1 | Command bit 7 |
| ch_xfer | output | 8 | Transfer type, 2 bits per channel |
| ch_autoinit | output | 4 | Autoinitialize, 1 bit per channel |
| ch_decr | output | 4 | Address decrement, 1 bit per channel |
| ch_mode | output | 8 | Service mode, 2 bits per channel |
| p_wdata | output | 8 | Byte of the last control write |
| p_req_wr | output | 1 | Request register write pulse |
| p_mask_one | output | 1 | Single mask bit write pulse |
| p_mask_all | output | 1 | All mask bits write pulse |
| p_ff_set | output | 1 | Byte flip-flop set pulse |
| p_ff_clr | output | 1 | Byte flip-flop clear pulse |
| p_mclr | output | 1 | Master clear pulse |
| p_clr_mask | output | 1 | Clear all masks pulse |
| p_status_rd | output | 1 | Status read pulse |

## Verification
The hardest state to reach from the ports is the readback counter in the middle of a sequence when a command disturbs it. The counter is not visible except through the data it selects. The stimulus therefore first writes four mode bytes with distinct fields. It then reads the shared location five times to expose the order and the wrap. After that it stops partway through the sequence, issues master clear or a counter-clear read, and checks that the next read returns channel 0 again. Held strobes of several cycles are also driven, to show that a single pulse and an unchanged counter follow.

// File: rtl/dma_regfront.sv
module dma_regfront (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic [7:0] status_in,
  input  logic [3:0] req_in,
  input  logic [3:0] mask_in,
  input  logic [7:0] temp_in,
  output logic [7:0] rdata,
  output logic       mem2mem_en,
  output logic       ch0_hold,
  output logic       ctrl_off,
  output logic       timing_short,
  output logic       prio_rotate,
  output logic       write_ext,
  output logic       dreq_inv,
  output logic       dack_hi,
  output logic [7:0] ch_xfer,
  output logic [3:0] ch_autoinit,
  output logic [3:0] ch_decr,
  output logic [7:0] ch_mode,
  output logic [7:0] p_wdata,
  output logic       p_req_wr,
  output logic       p_mask_one,
  output logic       p_mask_all,
  output logic       p_ff_set,
  output logic       p_ff_clr,
  output logic       p_mclr,
  output logic       p_clr_mask,
  output logic       p_status_rd
);

  logic [7:0] cmd_q;
  logic [5:0] mode_q [4];
  logic [1:0] mcnt;
  logic       wr_q, rd_q;
  logic       wr_go, rd_go;

  assign wr_go = wr_en & ~wr_q & addr[3];
  assign rd_go = rd_en & ~rd_q & addr[3];

  assign {dack_hi, dreq_inv, write_ext, prio_rotate,
          timing_short, ctrl_off, ch0_hold, mem2mem_en} = cmd_q;

  for (genvar c = 0; c < 4; c++) begin : g_ch
    assign ch_xfer[2*c +: 2] = mode_q[c][1:0];
    assign ch_autoinit[c]    = mode_q[c][2];
    assign ch_decr[c]        = mode_q[c][3];
    assign ch_mode[2*c +: 2] = mode_q[c][5:4];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      for (int c = 0; c < 4; c++) mode_q[c] <= '0;
      mcnt        <= '0;
      wr_q        <= 1'b0;
      rd_q        <= 1'b0;
      rdata       <= '0;
      p_wdata     <= '0;
      p_req_wr    <= 1'b0;
      p_mask_one  <= 1'b0;
      p_mask_all  <= 1'b0;
      p_ff_set    <= 1'b0;
      p_ff_clr    <= 1'b0;
      p_mclr      <= 1'b0;
      p_clr_mask  <= 1'b0;
      p_status_rd <= 1'b0;
    end else begin
      wr_q        <= wr_en;
      rd_q        <= rd_en;
      p_req_wr    <= 1'b0;
      p_mask_one  <= 1'b0;
      p_mask_all  <= 1'b0;
      p_ff_set    <= 1'b0;
      p_ff_clr    <= 1'b0;
      p_mclr      <= 1'b0;
      p_clr_mask  <= 1'b0;
      p_status_rd <= 1'b0;

      if (rd_go) begin
        case (addr[2:0])
          3'd0: begin rdata <= status_in; p_status_rd <= 1'b1; end
          3'd1: rdata <= {4'hF, req_in};
          3'd2: rdata <= cmd_q;
          3'd3: begin rdata <= {mode_q[mcnt], 2'b11}; mcnt <= mcnt + 2'd1; end
          3'd4: begin rdata <= 8'h00; p_ff_set <= 1'b1; end
          3'd5: rdata <= temp_in;
          3'd6: begin rdata <= 8'h00; mcnt <= 2'd0; end
          default: rdata <= {4'hF, mask_in};
        endcase
      end

      if (wr_go) begin
        p_wdata <= wdata;
        case (addr[2:0])
          3'd0: cmd_q <= wdata;
          3'd1: p_req_wr <= 1'b1;
          3'd2: p_mask_one <= 1'b1;
          3'd3: mode_q[wdata[1:0]] <= wdata[7:2];
          3'd4: p_ff_clr <= 1'b1;
          3'd5: begin p_mclr <= 1'b1; cmd_q <= '0; mcnt <= 2'd0; end
          3'd6: p_clr_mask <= 1'b1;
          default: p_mask_all <= 1'b1;
        endcase
      end
    end
  end

  AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    p_mclr |-> (cmd_q == 8'h00)); // R7

  AST_CMD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_q && (addr == 4'b1000 || addr == 4'b1101)) |=> $stable(cmd_q)); // R2

  AST_MCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_q && addr == 4'b1011 && !(wr_en && !wr_q && addr == 4'b1101))
      |=> (mcnt == $past(mcnt) + 2'd1)); // R4

  AST_WR_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p_req_wr, p_mask_one, p_mask_all, p_ff_clr, p_mclr, p_clr_mask})); // R8

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (p_mclr || p_clr_mask || p_ff_set) |=> !(p_mclr || p_clr_mask || p_ff_set)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !rd_q && addr[3]) |=> $stable(rdata)); // R10

  AST_LOW_PAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !addr[3]) |=> !(p_req_wr || p_mask_one || p_mask_all ||
      p_ff_set || p_ff_clr || p_mclr || p_clr_mask || p_status_rd)); // R11

endmodule

// File: tb/dma_regfront_bench.sv
module dma_regfront_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] status_in = 8'h93;
  logic [3:0] req_in = 4'h6;
  logic [3:0] mask_in = 4'h9;
  logic [7:0] temp_in = 8'hC4;
  logic [7:0] rdata, p_wdata, ch_xfer, ch_mode;
  logic [3:0] ch_autoinit, ch_decr;
  logic mem2mem_en, ch0_hold, ctrl_off, timing_short, prio_rotate, write_ext, dreq_inv, dack_hi;
  logic p_req_wr, p_mask_one, p_mask_all, p_ff_set, p_ff_clr, p_mclr, p_clr_mask, p_status_rd;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] pv;
  int pn;

  always #5 clk = ~clk;

  dma_regfront u_dma_regfront (.*);

  wire [7:0] pulses = {p_req_wr, p_mask_one, p_mask_all, p_ff_set,
                       p_ff_clr, p_mclr, p_clr_mask, p_status_rd};
  wire [7:0] cmd_bits = {dack_hi, dreq_inv, write_ext, prio_rotate,
                         timing_short, ctrl_off, ch0_hold, mem2mem_en};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(bit rd, logic [3:0] a, logic [7:0] d, int hold);
    pv = '0; pn = 0;
    @(negedge clk);
    addr = a; wdata = d; wr_en = !rd; rd_en = rd;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      pv |= pulses; pn += (pulses != 0);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    pv |= pulses; pn += (pulses != 0);
  endtask

  // op, addr, data, expected rdata (reads only)
  localparam logic [20:0] VEC [16] = '{
    {1'b0, 4'b1011, 8'hA4, 8'h00},
    {1'b0, 4'b1011, 8'h55, 8'h00},
    {1'b0, 4'b1011, 8'hCA, 8'h00},
    {1'b0, 4'b1011, 8'h3B, 8'h00},
    {1'b1, 4'b1110, 8'h77, 8'h00},
    {1'b1, 4'b1011, 8'h00, 8'hA7},
    {1'b1, 4'b1011, 8'h00, 8'h57},
    {1'b1, 4'b1011, 8'h00, 8'hCB},
    {1'b1, 4'b1011, 8'h00, 8'h3B},
    {1'b1, 4'b1011, 8'h00, 8'hA7},
    {1'b0, 4'b1000, 8'h5A, 8'h00},
    {1'b1, 4'b1010, 8'h00, 8'h5A},
    {1'b1, 4'b1000, 8'h00, 8'h93},
    {1'b1, 4'b1001, 8'h00, 8'hF6},
    {1'b1, 4'b1111, 8'h00, 8'hF9},
    {1'b1, 4'b1101, 8'h00, 8'hC4}
  };

  initial begin
    #(20000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cmd", cmd_bits, 8'h00);
    check("R1 modes", {ch_xfer, ch_mode, ch_autoinit, ch_decr}, 24'h0);
    check("R1 pulses", pulses, 8'h00);
    check("R1 rdata/pwdata", {rdata, p_wdata}, 16'h0);

    foreach (VEC[i]) begin
      op(VEC[i][20], VEC[i][19:16], VEC[i][15:8], 1);
      if (VEC[i][20] && VEC[i][19:16] != 4'b1110)
        check(VEC[i][19:16] == 4'b1011 ? "R4 mode readback" : "R9 read", rdata, VEC[i][7:0]);
      if (VEC[i][20] && VEC[i][19:16] == 4'b1110)
        check("R9 blank read", rdata, 8'h00);
    end

    check("R2 command decode", cmd_bits, 8'h5A);
    check("R3 xfer", ch_xfer, 8'b10_10_01_01);
    check("R3 mode", ch_mode, 8'b00_11_01_10);
    check("R3 autoinit", ch_autoinit, 4'b1010);
    check("R3 decr", ch_decr, 4'b1001);

    op(1'b0, 4'b1001, 8'h15, 1); check("R8 req pulse", pv, 8'h80); check("R8 data", p_wdata, 8'h15);
    op(1'b0, 4'b1010, 8'h06, 1); check("R8 single mask pulse", pv, 8'h40);
    op(1'b0, 4'b1111, 8'h0C, 1); check("R8 all mask pulse", pv, 8'h20); check("R8 data all", p_wdata, 8'h0C);
    op(1'b1, 4'b1100, 8'hFF, 1); check("R6 ff set", pv, 8'h10);
    op(1'b0, 4'b1100, 8'h00, 1); check("R6 ff clr", pv, 8'h08);
    op(1'b0, 4'b1110, 8'hFF, 1); check("R5 clear mask", pv, 8'h02);
    op(1'b1, 4'b1000, 8'h00, 1); check("R9 status pulse", pv, 8'h01);
    check("R2 cmd kept", cmd_bits, 8'h5A);

    // counter mid-sequence, then master clear
    op(1'b1, 4'b1011, 8'h00, 1);
    op(1'b1, 4'b1011, 8'h00, 1); check("R4 second read", rdata, 8'hCB);
    op(1'b0, 4'b1101, 8'hA5, 1); check("R7 mclr pulse", pv, 8'h04);
    check("R7 cmd cleared", cmd_bits, 8'h00);
    check("R7 modes kept", ch_mode, 8'b00_11_01_10);
    op(1'b1, 4'b1011, 8'h00, 1); check("R7 counter reset", rdata, 8'hA7);

    // held strobes: one pulse, one counter step
    op(1'b0, 4'b1110, 8'h00, 4); check("R10 held write single pulse", pn, 1);
    op(1'b1, 4'b1011, 8'h00, 4); check("R10 held read no re-step", rdata, 8'h57);
    op(1'b1, 4'b1011, 8'h00, 1); check("R10 next channel", rdata, 8'hCB);
    op(1'b1, 4'b1110, 8'h3C, 1);
    op(1'b1, 4'b1011, 8'h00, 1); check("R5 counter clear read", rdata, 8'hA7);

    // low page ignored
    op(1'b0, 4'b1000, 8'h81, 1);
    op(1'b0, 4'b0000, 8'hFF, 1); check("R11 no pulse wr", pv, 8'h00);
    check("R11 cmd unchanged", cmd_bits, 8'h81);
    op(1'b0, 4'b0011, 8'hFF, 1); check("R11 modes unchanged", ch_mode, 8'b00_11_01_10);
    op(1'b1, 4'b0011, 8'h00, 1); check("R11 rdata held", rdata, 8'hA7); check("R11 no pulse rd", pv, 8'h00);
    op(1'b1, 4'b1011, 8'h00, 1); check("R11 counter untouched", rdata, 8'h57);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset again", {cmd_bits, ch_mode, rdata}, 24'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule